// File: doc/BRIEF.md
# Two-Wire Controller Status Flag Unit

This block keeps the 32-bit read-only status word of a two-wire serial controller that can run as bus master or as slave. The protocol engine feeds it level signals (transfer complete, receive buffer full, transmit buffer free, slave read direction, slave addressed, clock held low) and single-cycle event pulses (arbitration lost, missing acknowledge, general call address seen, receive buffer written). The bus interface supplies a read strobe for the status word.

Level flags are registered copies of their inputs. Event flags are sticky until the word is read. If an event and a read fall in the same cycle, the event wins. The end-of-slave-access flag is derived inside the block from the falling edge of the registered slave-access flag. A lost arbitration or a master-mode missing acknowledge also raises transfer complete at the same edge. The word on `status_o` is combinational from the flag registers, so a read always sees the value from before its own clear.

Top module: `twi_status_unit`

## Requirements
- R1: During and after reset, before any stimulus, `status_o` equals 0x0000F009. Bits 15:12 always read 1. Bit 7 and bits 31:16 always read 0.
- R2: The level flags show their input one clock later: bit 0 `txcomp_i`, bit 1 `rxrdy_i`, bit 2 `txrdy_i`, bit 3 `svread_i`, bit 4 `svacc_i`, bit 10 `sclws_i`.
- R3: An `arb_lost_i` pulse with `master_mode_i`=1 sets bit 9 and bit 0 at the next edge. With `master_mode_i`=0 the pulse is ignored.
- R4: A `nack_i` pulse with `master_mode_i`=1 sets bit 8 and bit 0 at the next edge.
- R5: With `master_mode_i`=0, a `nack_i` pulse sets bit 8 only when `svread_i`=1. When `svread_i`=0 (slave write) the pulse is ignored.
- R6: With `master_mode_i`=0, an `rhr_load_i` pulse sets bit 6 (overrun) only while status bit 1 is already 1.
- R7: A `gcall_i` pulse sets bit 5 only when `master_mode_i`=0.
- R8: With `master_mode_i`=0, bit 11 becomes 1 at the same edge at which bit 4 falls from 1 to 0. In master mode it is not set.
- R9: Bits 5, 6, 8, 9 and 11 stay set until a cycle with `rd_i`=1. That cycle's clock edge clears them.
- R10: When a set condition and `rd_i` occur in the same cycle, the flag ends up set.
- R11: While `rd_i` is high, `status_o` shows the flags as they were before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_mode_i | input | 1 | 1 = controller acts as master |
| txcomp_i | input | 1 | Transfer complete level |
| rxrdy_i | input | 1 | Receive buffer full level |
| txrdy_i | input | 1 | Transmit buffer free level |
| svread_i | input | 1 | Slave read direction level |
| svacc_i | input | 1 | Slave addressed level |
| sclws_i | input | 1 | Clock stretched level |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| nack_i | input | 1 | Acknowledge missing pulse |
| gcall_i | input | 1 | General call pulse |
| rhr_load_i | input | 1 | Receive buffer write pulse |
| rd_i | input | 1 | Status read strobe |
| status_o | output | 32 | Status word |

## Verification
Two functions can hit the same edge: a sticky flag's set event and the clear caused by a status read. The bench provokes this by raising `gcall_i` and `rd_i` together in slave mode, then checks that bit 5 is set afterwards and is cleared by the next lone read. A second overlap is a lost arbitration or missing acknowledge coinciding with transfer complete. The bench sweeps every combination of mode, direction and event, and checks both bit 0 and the event bit after the same edge.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;
  localparam int STAT_W  = 32;
  localparam int LIVE_N  = 6;
  localparam int STICK_N = 5;
  localparam logic [STAT_W-1:0] RSV_ONES = 32'h0000_F000;
  // live order: txcomp, rxrdy, txrdy, svread, svacc, sclws
  localparam logic [LIVE_N-1:0] LIVE_RST = 6'b00_1001;
  // sticky order: gcall, ovr, nack, arb, eos
  localparam logic [STICK_N-1:0] STICK_RST = '0;

  function automatic int live_pos(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return 4;
      default: return 10;
    endcase
  endfunction

  function automatic int stick_pos(input int i);
    case (i)
      0: return 5;
      1: return 6;
      2: return 8;
      3: return 9;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/twi_stat_live.sv
module twi_stat_live
  import twi_stat_pkg::*;
#(
  parameter int N = LIVE_N,
  parameter logic [N-1:0] RST = LIVE_RST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  input  logic         force_txc_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] nxt;
  always_comb begin
    nxt    = lvl_i;
    nxt[0] = lvl_i[0] | force_txc_i;
  end
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= RST;
    else         q_o <= nxt;
endmodule

// File: rtl/twi_stat_sticky.sv
module twi_stat_sticky #(
  parameter logic RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= RST;
    else if (set_i) q_o <= 1'b1;  // set beats read-clear
    else if (clr_i) q_o <= 1'b0;
endmodule

// File: rtl/twi_stat_events.sv
module twi_stat_events
  import twi_stat_pkg::*;
(
  input  logic               master_mode_i,
  input  logic               svread_i,
  input  logic               svacc_i,
  input  logic               svacc_q_i,
  input  logic               rxrdy_q_i,
  input  logic               arb_lost_i,
  input  logic               nack_i,
  input  logic               gcall_i,
  input  logic               rhr_load_i,
  output logic [STICK_N-1:0] set_o,
  output logic               force_txc_o
);
  logic slv, arb_set, nak_mst;
  assign slv     = ~master_mode_i;
  assign arb_set = arb_lost_i & master_mode_i;
  assign nak_mst = nack_i & master_mode_i;
  always_comb begin
    set_o[0] = gcall_i & slv;
    set_o[1] = rhr_load_i & rxrdy_q_i & slv;
    set_o[2] = nak_mst | (nack_i & slv & svread_i);
    set_o[3] = arb_set;
    set_o[4] = svacc_q_i & ~svacc_i & slv;
  end
  assign force_txc_o = arb_set | nak_mst;
endmodule

// File: rtl/twi_status_unit.sv
module twi_status_unit
  import twi_stat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        master_mode_i,
  input  logic        txcomp_i,
  input  logic        rxrdy_i,
  input  logic        txrdy_i,
  input  logic        svread_i,
  input  logic        svacc_i,
  input  logic        sclws_i,
  input  logic        arb_lost_i,
  input  logic        nack_i,
  input  logic        gcall_i,
  input  logic        rhr_load_i,
  input  logic        rd_i,
  output logic [31:0] status_o
);
  logic [LIVE_N-1:0]  live_q;
  logic [STICK_N-1:0] stick_q, stick_set;
  logic               force_txc;

  twi_stat_events u_ev (
    .master_mode_i(master_mode_i), .svread_i(svread_i), .svacc_i(svacc_i),
    .svacc_q_i(live_q[4]), .rxrdy_q_i(live_q[1]), .arb_lost_i(arb_lost_i),
    .nack_i(nack_i), .gcall_i(gcall_i), .rhr_load_i(rhr_load_i),
    .set_o(stick_set), .force_txc_o(force_txc)
  );

  twi_stat_live #(.N(LIVE_N), .RST(LIVE_RST)) u_live (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lvl_i({sclws_i, svacc_i, svread_i, txrdy_i, rxrdy_i, txcomp_i}),
    .force_txc_i(force_txc), .q_o(live_q)
  );

  for (genvar g = 0; g < STICK_N; g++) begin : g_stick
    twi_stat_sticky #(.RST(STICK_RST[g])) u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stick_set[g]),
      .clr_i(rd_i), .q_o(stick_q[g])
    );
  end

  always_comb begin
    status_o = RSV_ONES;
    for (int i = 0; i < LIVE_N; i++)  status_o[live_pos(i)]  = live_q[i];
    for (int i = 0; i < STICK_N; i++) status_o[stick_pos(i)] = stick_q[i];
  end
endmodule

// File: rtl/twi_status_unit_chk.sv
module twi_status_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        master_mode_i,
  input logic        svread_i,
  input logic        sclws_i,
  input logic        arb_lost_i,
  input logic        nack_i,
  input logic        gcall_i,
  input logic        rhr_load_i,
  input logic        rd_i,
  input logic [31:0] status_o
);
  // R2
  ws_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> status_o[10] == $past(sclws_i));
  // R3
  arb_txc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i && master_mode_i |=> status_o[9] && status_o[0]);
  // R4
  nak_txc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i && master_mode_i |=> status_o[8] && status_o[0]);
  // R5
  slv_wr_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_i && !master_mode_i && !svread_i && !status_o[8] |=> !status_o[8]);
  // R8
  eos_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[4]) && !$past(master_mode_i) |-> status_o[11]);
  // R9
  ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] && !rd_i |=> status_o[6]);
  // R9
  gc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !gcall_i |=> !status_o[5]);
  // R10
  set_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && gcall_i && !master_mode_i |=> status_o[5]);
  // R6
  ovr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rhr_load_i && !status_o[1] && !status_o[6] |=> !status_o[6]);
endmodule

bind twi_status_unit twi_status_unit_chk u_chk (.*);

// File: tb/twi_status_unit_test.sv
`timescale 1ns/1ps
module twi_status_unit_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic master_mode_i = 1'b0, txcomp_i = 1'b1, rxrdy_i = 1'b0, txrdy_i = 1'b0;
  logic svread_i = 1'b1, svacc_i = 1'b0, sclws_i = 1'b0;
  logic arb_lost_i = 1'b0, nack_i = 1'b0, gcall_i = 1'b0, rhr_load_i = 1'b0, rd_i = 1'b0;
  logic [31:0] status_o;
  int total = 0, bad = 0;

  always #2.5 clk_i = ~clk_i;

  twi_status_unit uut (.*);

  task automatic tick;
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd_clear;
    rd_i = 1'b1; tick; rd_i = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick; tick;
    chk("R1 in reset", status_o, 32'h0000_F009);
    rst_ni = 1'b1; tick;
    chk("R1 after reset", status_o, 32'h0000_F009);

    // R2 sweep of all live level combinations
    for (int v = 0; v < 64; v++) begin
      {sclws_i, svacc_i, svread_i, txrdy_i, rxrdy_i, txcomp_i} = 6'(v);
      tick;
      chk("R2 live", status_o & 32'h0000_041F, {21'd0, 1'(v >> 5), 5'd0, 5'(v)});
      chk("R1 reserved", status_o & 32'hFFFF_F080, 32'h0000_F000);
    end
    {sclws_i, svacc_i, svread_i, txrdy_i, rxrdy_i, txcomp_i} = '0;
    tick; rd_clear; tick;
    chk("R9 cleared", status_o, 32'h0000_F000);

    // R3 R4 R5 R6 R7 sweep over mode, direction and event
    for (int mm = 0; mm < 2; mm++)
      for (int sr = 0; sr < 2; sr++)
        for (int ev = 0; ev < 4; ev++) begin
          master_mode_i = 1'(mm); svread_i = 1'(sr);
          rxrdy_i = (ev == 3); tick;
          case (ev)
            0: begin arb_lost_i = 1; tick; arb_lost_i = 0;
                 chk("R3 arb", {31'd0, status_o[9]}, 32'(mm));
                 chk("R3 txc", {31'd0, status_o[0]}, 32'(mm)); end
            1: begin nack_i = 1; tick; nack_i = 0;
                 chk("R4 R5 nack", {31'd0, status_o[8]}, 32'(mm | sr));
                 chk("R4 txc", {31'd0, status_o[0]}, 32'(mm)); end
            2: begin gcall_i = 1; tick; gcall_i = 0;
                 chk("R7 gcall", {31'd0, status_o[5]}, 32'(1 - mm)); end
            default: begin rhr_load_i = 1; tick; rhr_load_i = 0;
                 chk("R6 ovr", {31'd0, status_o[6]}, 32'(1 - mm)); end
          endcase
          rxrdy_i = 0; svread_i = 0; tick; rd_clear;
        end

    // R6 no overrun while receive flag clear
    master_mode_i = 0; tick;
    rhr_load_i = 1; tick; rhr_load_i = 0;
    chk("R6 no ovr", {31'd0, status_o[6]}, 32'd0);

    // R8 end of slave access
    svacc_i = 1; tick;
    chk("R8 during access", {30'd0, status_o[11], status_o[4]}, 32'd1);
    svacc_i = 0; tick;
    chk("R8 on fall", {30'd0, status_o[11], status_o[4]}, 32'd2);
    tick; tick;
    chk("R9 hold", {31'd0, status_o[11]}, 32'd1);
    rd_i = 1;
    #0.5 chk("R11 pre-clear view", {31'd0, status_o[11]}, 32'd1);
    tick; rd_i = 0;
    chk("R9 read clears", {31'd0, status_o[11]}, 32'd0);
    master_mode_i = 1; svacc_i = 1; tick; svacc_i = 0; tick;
    chk("R8 master ignored", {31'd0, status_o[11]}, 32'd0);

    // R10 set and read in same cycle
    master_mode_i = 0; tick;
    gcall_i = 1; rd_i = 1; tick; gcall_i = 0; rd_i = 0;
    chk("R10 set wins", {31'd0, status_o[5]}, 32'd1);
    rd_clear;
    chk("R9 gcall clear", {31'd0, status_o[5]}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule